// File: doc/BRIEF.md
# Store Miss Coalescing Buffer

This block sits between a data cache's store-miss path and the system bus. Each store that misses is folded into a line-sized staging entry. The entry holds the block address, a full line of data and one valid bit per byte. Later stores to the same block land in that entry straight away, so they never wait for the line to arrive from memory.

When an entry is closed, a drain engine picks the bus transaction for it. If every byte of the line has been written, the engine sends an address-only ownership claim and fetches no data. Otherwise it requests a line read. It then combines the returned bytes with the stored bytes, and the stored bytes take priority. In both cases the finished line is presented once on a write port into the cache.

Only one entry is open for merging at a time. An entry closes when a store to another block arrives, when it has been idle too long, or when a flush is requested. Store input stalls when no entry is free.

Top module: `store_merge_buf`

## Requirements
- R1: After reset `st_ready` is 1, and `bus_req_valid` and `wr_valid` are 0.
- R2: A store to the block held by the open entry is accepted in the cycle it is presented, and it causes no bus request while the entry stays open.
- R3: Store bytes are placed at line offset (word index × store width + lane), where the word index is taken from address bits above the lane bits and below the line-offset boundary. A later store to the same offset replaces the earlier byte.
- R4: A closed entry whose byte mask is all ones issues a request with `bus_req_claim`=1 (address-only claim). It takes no fill, and the line written to the cache is exactly the stored bytes.
- R5: A closed entry with any mask bit clear issues a request with `bus_req_claim`=0 (line read). It waits for `fill_valid`, and then writes the line with stored bytes where the mask is set and fill bytes where it is clear.
- R6: A store presented to a block other than the open entry's block closes the open entry. That entry's bus request is visible within 3 cycles after the store is accepted.
- R7: An open entry that receives no store for TIMEOUT cycles closes by itself. Its request becomes visible no earlier than TIMEOUT and no later than TIMEOUT+3 cycles after the last accepted store.
- R8: A one-cycle `flush` pulse closes the open entry, and its request is visible within 3 cycles.
- R9: A store whose block matches an entry that is closed or in flight is stalled (`st_ready`=0) until that entry's line has been written to the cache.
- R10: When no entry is free and the store does not hit the open entry, `st_ready` is 0.
- R11: Every closed entry produces exactly one request and then one single-cycle write. The request stays stable until `bus_req_ready`. Both addresses are the block address with the line-offset bits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store miss presented |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | AW | Store byte address |
| st_data | input | STORE_BYTES*8 | Store data, lane 0 in the low byte |
| st_be | input | STORE_BYTES | Per-lane byte enables |
| flush | input | 1 | Close the open entry |
| bus_req_valid | output | 1 | Bus transaction request |
| bus_req_ready | input | 1 | Bus accepts the request |
| bus_req_claim | output | 1 | 1 = address-only claim, 0 = line read |
| bus_req_addr | output | AW | Line-aligned block address |
| fill_valid | input | 1 | Line data returned for the outstanding read |
| fill_data | input | LINE_BYTES*8 | Returned line, byte 0 in the low byte |
| wr_valid | output | 1 | Completed line write into the cache |
| wr_addr | output | AW | Line-aligned address of the written line |
| wr_data | output | LINE_BYTES*8 | Completed line |

## Verification
A corrupted byte mask shows up in the first request after the entry closes: a claim where a read is due, or a read where a claim is due. It also shows up in the line written later, where a fill byte overwrites a stored byte. A wrong entry state, such as an open entry left open or a closed one accepting merges, shows up as a request that is missing, early or late relative to the store, timeout or flush that should cause it, or as data arriving in the wrong line. Every line written is compared byte by byte against a model built from the accepted stores and the fill pattern at the moment it appears.

// File: rtl/smb_pkg.sv
package smb_pkg;

   typedef enum logic [1:0] {
      ENT_FREE = 2'd0,
      ENT_OPEN = 2'd1,
      ENT_SHUT = 2'd2,
      ENT_BUSY = 2'd3
   } ent_state_e;

   typedef enum logic [1:0] {
      DR_IDLE  = 2'd0,
      DR_REQ   = 2'd1,
      DR_FILL  = 2'd2,
      DR_WRITE = 2'd3
   } drain_state_e;

endpackage

// File: rtl/smb_line_entry.sv
module smb_line_entry
   import smb_pkg::*;
#(
   parameter int TAGW        = 27,
   parameter int LINE_BYTES  = 32,
   parameter int STORE_BYTES = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          alloc_i,
   input  logic [TAGW-1:0]               tag_i,
   input  logic                          merge_i,
   input  logic [$clog2(LINE_BYTES/STORE_BYTES)-1:0] word_i,
   input  logic [STORE_BYTES*8-1:0]      data_i,
   input  logic [STORE_BYTES-1:0]        be_i,
   input  logic                          close_i,
   input  logic                          issue_i,
   input  logic                          release_i,
   output ent_state_e                    state_o,
   output logic [TAGW-1:0]               tag_o,
   output logic [LINE_BYTES*8-1:0]       line_o,
   output logic [LINE_BYTES-1:0]         mask_o
);

   localparam int LW = LINE_BYTES * 8;

   ent_state_e            state_q;
   logic [TAGW-1:0]       tag_q;
   logic [LW-1:0]         line_q, line_n;
   logic [LINE_BYTES-1:0] mask_q, mask_n;

   always_comb begin
      mask_n = alloc_i ? '0 : mask_q;
      line_n = line_q;
      if (merge_i) begin
         for (int s = 0; s < STORE_BYTES; s++) begin
            if (be_i[s]) begin
               mask_n[int'(word_i) * STORE_BYTES + s]           = 1'b1;
               line_n[(int'(word_i) * STORE_BYTES + s) * 8 +: 8] = data_i[s*8 +: 8];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENT_FREE;
         tag_q   <= '0;
         line_q  <= '0;
         mask_q  <= '0;
      end else begin
         line_q <= line_n;
         mask_q <= mask_n;
         if (alloc_i) begin
            tag_q   <= tag_i;
            state_q <= ENT_OPEN;
         end
         if (close_i)   state_q <= ENT_SHUT;
         if (issue_i)   state_q <= ENT_BUSY;
         if (release_i) state_q <= ENT_FREE;
      end
   end

   assign state_o = state_q;
   assign tag_o   = tag_q;
   assign line_o  = line_q;
   assign mask_o  = mask_q;

   // R10: allocation only ever lands on an empty entry
   p_alloc_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_i |-> state_q == ENT_FREE);

   // R9: bytes never merge into a closed or in-flight line
   p_merge_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (merge_i && !alloc_i) |-> state_q == ENT_OPEN);

   // R6: the drain only takes entries that were closed
   p_issue_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |-> state_q == ENT_SHUT);

endmodule

// File: rtl/smb_drain_ctl.sv
module smb_drain_ctl
   import smb_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 32,
   parameter int NENT       = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NENT-1:0]             shut_i,
   input  logic [AW-$clog2(LINE_BYTES)-1:0] tag_i [NENT],
   input  logic [LINE_BYTES*8-1:0]     line_i [NENT],
   input  logic [LINE_BYTES-1:0]       mask_i [NENT],
   output logic [NENT-1:0]             issue_o,
   output logic [NENT-1:0]             release_o,
   output logic                        bus_req_valid,
   input  logic                        bus_req_ready,
   output logic                        bus_req_claim,
   output logic [AW-1:0]               bus_req_addr,
   input  logic                        fill_valid,
   input  logic [LINE_BYTES*8-1:0]     fill_data,
   output logic                        wr_valid,
   output logic [AW-1:0]               wr_addr,
   output logic [LINE_BYTES*8-1:0]     wr_data
);

   localparam int OFFW = $clog2(LINE_BYTES);
   localparam int LW   = LINE_BYTES * 8;
   localparam int IDXW = (NENT > 1) ? $clog2(NENT) : 1;

   drain_state_e    dst_q;
   logic [IDXW-1:0] sel_q, pick;
   logic            any_shut, claim_q;
   logic [LW-1:0]   buf_q, fill_mix;

   always_comb begin
      any_shut  = 1'b0;
      pick      = '0;
      issue_o   = '0;
      release_o = '0;
      for (int i = NENT - 1; i >= 0; i--) begin
         if (shut_i[i]) begin
            any_shut = 1'b1;
            pick     = IDXW'(i);
         end
      end
      if (dst_q == DR_IDLE && any_shut) issue_o[pick] = 1'b1;
      if (dst_q == DR_WRITE)            release_o[sel_q] = 1'b1;
   end

   always_comb begin
      for (int b = 0; b < LINE_BYTES; b++) begin
         fill_mix[b*8 +: 8] = mask_i[sel_q][b] ? line_i[sel_q][b*8 +: 8] : fill_data[b*8 +: 8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dst_q   <= DR_IDLE;
         sel_q   <= '0;
         claim_q <= 1'b0;
         buf_q   <= '0;
      end else begin
         unique case (dst_q)
            DR_IDLE: if (any_shut) begin
               sel_q   <= pick;
               claim_q <= &mask_i[pick];
               dst_q   <= DR_REQ;
            end
            DR_REQ: if (bus_req_ready) begin
               if (claim_q) begin
                  buf_q <= line_i[sel_q];
                  dst_q <= DR_WRITE;
               end else begin
                  dst_q <= DR_FILL;
               end
            end
            DR_FILL: if (fill_valid) begin
               buf_q <= fill_mix;
               dst_q <= DR_WRITE;
            end
            DR_WRITE: dst_q <= DR_IDLE;
            default:  dst_q <= DR_IDLE;
         endcase
      end
   end

   assign bus_req_valid = (dst_q == DR_REQ);
   assign bus_req_claim = claim_q;
   assign bus_req_addr  = {tag_i[sel_q], {OFFW{1'b0}}};
   assign wr_valid      = (dst_q == DR_WRITE);
   assign wr_addr       = {tag_i[sel_q], {OFFW{1'b0}}};
   assign wr_data       = buf_q;

   // R4: a claim is only issued for a line the entry fully covers
   p_claim_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_req_claim) |-> (&mask_i[sel_q]));

   // R11: request held steady until the bus takes it
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_req_ready) |=>
         (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_claim)));

   // R11: one write cycle per drained entry
   p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);

   // R5: a read-path write is preceded by returned data
   p_read_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(wr_valid) && !bus_req_claim) |-> $past(fill_valid));

endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
   import smb_pkg::*;
#(
   parameter int AW          = 32,
   parameter int LINE_BYTES  = 32,
   parameter int STORE_BYTES = 8,
   parameter int NENT        = 4,
   parameter int TIMEOUT     = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      st_valid,
   output logic                      st_ready,
   input  logic [AW-1:0]             st_addr,
   input  logic [STORE_BYTES*8-1:0]  st_data,
   input  logic [STORE_BYTES-1:0]    st_be,
   input  logic                      flush,
   output logic                      bus_req_valid,
   input  logic                      bus_req_ready,
   output logic                      bus_req_claim,
   output logic [AW-1:0]             bus_req_addr,
   input  logic                      fill_valid,
   input  logic [LINE_BYTES*8-1:0]   fill_data,
   output logic                      wr_valid,
   output logic [AW-1:0]             wr_addr,
   output logic [LINE_BYTES*8-1:0]   wr_data
);

   localparam int OFFW  = $clog2(LINE_BYTES);
   localparam int LANEW = $clog2(STORE_BYTES);
   localparam int TAGW  = AW - OFFW;
   localparam int LW    = LINE_BYTES * 8;
   localparam int WIDXW = $clog2(LINE_BYTES / STORE_BYTES);
   localparam int IDXW  = (NENT > 1) ? $clog2(NENT) : 1;
   localparam int AGEW  = $clog2(TIMEOUT + 1);

   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || (STORE_BYTES & (STORE_BYTES - 1)) != 0)
   begin : g_bad_pow2
      initial $error("store_merge_buf: line and store widths must be powers of two");
   end
   if (LINE_BYTES < 2 * STORE_BYTES) begin : g_bad_ratio
      initial $error("store_merge_buf: a line must hold at least two store words");
   end
   if (NENT < 1 || TIMEOUT < 1 || AW <= OFFW) begin : g_bad_size
      initial $error("store_merge_buf: NENT, TIMEOUT and AW out of range");
   end

   ent_state_e            ent_st [NENT];
   logic [TAGW-1:0]       ent_tag [NENT];
   logic [LW-1:0]         ent_line [NENT];
   logic [LINE_BYTES-1:0] ent_mask [NENT];
   logic [NENT-1:0]       open_vec, shut_vec, issue_v, release_v;
   logic [NENT-1:0]       alloc_v, merge_v, close_v;

   logic                  open_any, free_any, pend_hit, open_hit;
   logic [IDXW-1:0]       open_idx, free_idx;
   logic [TAGW-1:0]       st_blk;
   logic [WIDXW-1:0]      st_word;
   logic                  st_fire, alloc_fire, close_open, age_close;
   logic [AGEW-1:0]       age_q;

   assign st_blk  = st_addr[AW-1:OFFW];
   assign st_word = st_addr[OFFW-1:LANEW];

   always_comb begin
      open_any = 1'b0;
      free_any = 1'b0;
      pend_hit = 1'b0;
      open_idx = '0;
      free_idx = '0;
      for (int i = NENT - 1; i >= 0; i--) begin
         open_vec[i] = (ent_st[i] == ENT_OPEN);
         shut_vec[i] = (ent_st[i] == ENT_SHUT);
         if (ent_st[i] == ENT_OPEN) begin
            open_any = 1'b1;
            open_idx = IDXW'(i);
         end
         if (ent_st[i] == ENT_FREE) begin
            free_any = 1'b1;
            free_idx = IDXW'(i);
         end
         if ((ent_st[i] == ENT_SHUT || ent_st[i] == ENT_BUSY) && ent_tag[i] == st_blk)
            pend_hit = 1'b1;
      end
   end

   assign open_hit   = open_any && (ent_tag[open_idx] == st_blk);
   assign st_ready   = !pend_hit && (open_hit || free_any);
   assign st_fire    = st_valid && st_ready;
   assign alloc_fire = st_fire && !open_hit;
   assign age_close  = !st_fire && (age_q == AGEW'(TIMEOUT - 1));
   assign close_open = open_any && ((st_valid && !open_hit) || flush || age_close);

   always_comb begin
      for (int i = 0; i < NENT; i++) begin
         alloc_v[i] = alloc_fire && (free_idx == IDXW'(i));
         merge_v[i] = alloc_v[i] || (st_fire && open_hit && (open_idx == IDXW'(i)));
         close_v[i] = close_open && (open_idx == IDXW'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                              age_q <= '0;
      else if (st_fire || !open_any)           age_q <= '0;
      else if (age_q != AGEW'(TIMEOUT - 1))    age_q <= age_q + 1'b1;
   end

   for (genvar g = 0; g < NENT; g++) begin : g_ent
      smb_line_entry #(
         .TAGW        (TAGW),
         .LINE_BYTES  (LINE_BYTES),
         .STORE_BYTES (STORE_BYTES)
      ) ent_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc_i   (alloc_v[g]),
         .tag_i     (st_blk),
         .merge_i   (merge_v[g]),
         .word_i    (st_word),
         .data_i    (st_data),
         .be_i      (st_be),
         .close_i   (close_v[g]),
         .issue_i   (issue_v[g]),
         .release_i (release_v[g]),
         .state_o   (ent_st[g]),
         .tag_o     (ent_tag[g]),
         .line_o    (ent_line[g]),
         .mask_o    (ent_mask[g])
      );
   end

   smb_drain_ctl #(
      .AW         (AW),
      .LINE_BYTES (LINE_BYTES),
      .NENT       (NENT)
   ) drain_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .shut_i        (shut_vec),
      .tag_i         (ent_tag),
      .line_i        (ent_line),
      .mask_i        (ent_mask),
      .issue_o       (issue_v),
      .release_o     (release_v),
      .bus_req_valid (bus_req_valid),
      .bus_req_ready (bus_req_ready),
      .bus_req_claim (bus_req_claim),
      .bus_req_addr  (bus_req_addr),
      .fill_valid    (fill_valid),
      .fill_data     (fill_data),
      .wr_valid      (wr_valid),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data)
   );

   // R6: at most one entry collects stores at any time
   p_one_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(open_vec) <= 1);

   // R8: a flush without a new allocation leaves nothing open
   p_flush_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !alloc_fire) |=> (open_vec == '0));

   // R9: a new block never shares its address with a pending entry
   p_no_dup_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> !open_hit || !st_valid || (wr_addr[AW-1:OFFW] != st_blk) || !st_ready);

endmodule

// File: tb/store_merge_buf_tb_top.sv
`timescale 1ns/100ps
module store_merge_buf_tb_top;

   localparam int AW = 32, LB = 32, SB = 8, NE = 4, TO = 16;
   localparam int OFFW = 5, LW = LB * 8, SW = SB * 8, NW = LB / SB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          st_valid = 1'b0, st_ready, flush = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [SW-1:0] st_data = '0;
   logic [SB-1:0] st_be = '0;
   logic          bus_req_valid, bus_req_ready = 1'b0, bus_req_claim;
   logic [AW-1:0] bus_req_addr, wr_addr;
   logic          fill_valid = 1'b0, wr_valid;
   logic [LW-1:0] fill_data = '0, wr_data;

   store_merge_buf #(.AW(AW), .LINE_BYTES(LB), .STORE_BYTES(SB), .NENT(NE), .TIMEOUT(TO)) dut_i (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
      .st_data(st_data), .st_be(st_be), .flush(flush), .bus_req_valid(bus_req_valid),
      .bus_req_ready(bus_req_ready), .bus_req_claim(bus_req_claim), .bus_req_addr(bus_req_addr),
      .fill_valid(fill_valid), .fill_data(fill_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data));

   int n_chk = 0, n_bad = 0;
   int req_cnt = 0, wr_cnt = 0;
   int last_req_blk = -1;
   logic last_req_claim = 1'b0;
   bit hold_bus = 1'b0;
   int fill_cd = 0, fill_blk = 0;

   logic [LW-1:0] m_data [int];
   logic [LB-1:0] m_mask [int];

   task automatic chk(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [LW-1:0] fill_line(input int blk);
      logic [LW-1:0] v;
      for (int i = 0; i < LB; i++) v[i*8 +: 8] = 8'((blk * 29 + i * 11 + 5) & 255);
      return v;
   endfunction

   function automatic void model_store(input int blk, input int w, input logic [SW-1:0] d, input logic [SB-1:0] be);
      logic [LW-1:0] ld;
      logic [LB-1:0] lm;
      if (m_data.exists(blk)) begin ld = m_data[blk]; lm = m_mask[blk]; end
      else begin ld = '0; lm = '0; end
      for (int s = 0; s < SB; s++) begin
         if (be[s]) begin
            ld[(w*SB+s)*8 +: 8] = d[s*8 +: 8];
            lm[w*SB+s] = 1'b1;
         end
      end
      m_data[blk] = ld;
      m_mask[blk] = lm;
   endfunction

   // Present one store, wait until taken; returns just after the accepting edge.
   task automatic do_store(input int blk, input int w, input logic [SW-1:0] d, input logic [SB-1:0] be);
      bit done;
      done = 1'b0;
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = (AW'(blk) << OFFW) | AW'(w * SB);
      st_data  = d;
      st_be    = be;
      while (!done) begin
         #1;
         if (st_ready) begin
            model_store(blk, w, d, be);
            done = 1'b1;
         end else begin
            @(negedge clk);
         end
      end
      @(posedge clk);
      #1 st_valid = 1'b0;
   endtask

   task automatic pulse_flush();
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk);
      #1 flush = 1'b0;
   endtask

   task automatic wait_empty(input string req);
      int n;
      n = 0;
      while ((m_data.num() != 0 || bus_req_valid || wr_valid || fill_cd != 0) && n < 2000) begin
         @(negedge clk); #1;
         n++;
      end
      chk(m_data.num() == 0, req, LW'(m_data.num()), '0);
   endtask

   // returns sample index at which a request is first seen (0 = never within limit)
   task automatic first_req(input int limit, output int at);
      at = 0;
      for (int k = 1; k <= limit && at == 0; k++) begin
         @(negedge clk); #1;
         if (bus_req_valid) at = k;
      end
   endtask

   // bus ready and fill drivers
   initial forever begin
      @(negedge clk);
      bus_req_ready = hold_bus ? 1'b0 : (($urandom % 4) != 0);
      if (fill_cd == 1) begin
         fill_valid = 1'b1;
         fill_data  = fill_line(fill_blk);
      end else begin
         fill_valid = 1'b0;
      end
      if (fill_cd > 0) fill_cd--;
   end

   // output monitor
   initial forever begin
      int b;
      logic [LW-1:0] exp;
      @(negedge clk); #1;
      if (rst_n) begin
         if (bus_req_valid && bus_req_ready) begin
            b = int'(bus_req_addr >> OFFW);
            req_cnt++;
            last_req_blk   = b;
            last_req_claim = bus_req_claim;
            chk(bus_req_addr[OFFW-1:0] == '0, "R11", LW'(bus_req_addr), '0);
            chk(m_mask.exists(b), "R11", LW'(b), '0);
            if (m_mask.exists(b))
               chk(bus_req_claim == (&m_mask[b]), (&m_mask[b]) ? "R4" : "R5",
                   LW'(bus_req_claim), LW'(&m_mask[b]));
            if (!bus_req_claim) begin
               fill_blk = b;
               fill_cd  = 1 + int'($urandom % 4);
            end
         end
         if (wr_valid) begin
            b = int'(wr_addr >> OFFW);
            wr_cnt++;
            chk(m_data.exists(b) && b == last_req_blk, "R11", LW'(b), LW'(last_req_blk));
            if (m_data.exists(b)) begin
               for (int i = 0; i < LB; i++)
                  exp[i*8 +: 8] = m_mask[b][i] ? m_data[b][i*8 +: 8] : fill_line(b)[i*8 +: 8];
               chk(wr_data == exp, (&m_mask[b]) ? "R4 R3" : "R5 R3", wr_data, exp);
               m_data.delete(b);
               m_mask.delete(b);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R11: watchdog expired, actual %0d writes expected %0d", wr_cnt, req_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int at, w0;
      void'($urandom(32'd24681));
      repeat (4) @(negedge clk);
      #1;
      chk(bus_req_valid == 1'b0 && wr_valid == 1'b0, "R1", LW'({bus_req_valid, wr_valid}), '0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(st_ready == 1'b1, "R1", LW'(st_ready), LW'(1));
      chk(bus_req_valid == 1'b0 && wr_valid == 1'b0, "R1", LW'({bus_req_valid, wr_valid}), '0);

      // R2 / R3: back-to-back merges with an overwrite, then R8 flush
      do_store(3, 0, 64'h1111_2222_3333_4444, 8'hFF);
      do_store(3, 0, 64'hAAAA_BBBB_CCCC_DDDD, 8'h0F);
      do_store(3, 2, 64'h9988_7766_5544_3322, 8'h81);
      @(negedge clk); #1;
      chk(bus_req_valid == 1'b0 && st_ready == 1'b1, "R2", LW'({bus_req_valid, st_ready}), LW'(1));
      pulse_flush();
      first_req(3, at);
      chk(at != 0, "R8", LW'(at), LW'(2));
      wait_empty("R8");

      // R4: full coverage becomes an address-only claim
      for (int w = 0; w < NW; w++) do_store(5, w, {2{32'hC0DE_0000 | 32'(w)}}, 8'hFF);
      pulse_flush();
      wait_empty("R4");
      chk(last_req_blk == 5 && last_req_claim == 1'b1, "R4", LW'(last_req_claim), LW'(1));

      // R5: partial coverage needs a fill
      do_store(6, 1, 64'h0123_4567_89AB_CDEF, 8'h3C);
      pulse_flush();
      wait_empty("R5");
      chk(last_req_blk == 6 && last_req_claim == 1'b0, "R5", LW'(last_req_claim), '0);

      // R7: idle timeout closes the entry
      do_store(7, 3, 64'h5A5A_5A5A_5A5A_5A5A, 8'hF0);
      first_req(TO + 8, at);
      chk(at >= TO && at <= TO + 3, "R7", LW'(at), LW'(TO + 2));
      wait_empty("R7");

      // R6: a different block closes the open entry
      do_store(8, 0, 64'h1, 8'h01);
      do_store(9, 1, 64'h2, 8'h02);
      first_req(3, at);
      chk(at != 0 && int'(bus_req_addr >> OFFW) == 8, "R6", LW'(bus_req_addr >> OFFW), LW'(8));
      pulse_flush();
      wait_empty("R6");

      // R9: same block as a pending entry stalls until written
      hold_bus = 1'b1;
      do_store(10, 0, 64'h77, 8'h01);
      pulse_flush();
      w0 = wr_cnt;
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = AW'(10) << OFFW;
      st_data  = 64'h88;
      st_be    = 8'h02;
      for (int k = 0; k < 4; k++) begin
         #1;
         chk(st_ready == 1'b0, "R9", LW'(st_ready), '0);
         @(negedge clk);
      end
      st_valid = 1'b0;
      hold_bus = 1'b0;
      do_store(10, 0, 64'h8800, 8'h02);
      chk(wr_cnt == w0 + 1, "R9", LW'(wr_cnt), LW'(w0 + 1));
      pulse_flush();
      wait_empty("R9");

      // R10: all entries occupied stalls a new block
      hold_bus = 1'b1;
      for (int k = 0; k < NE; k++) do_store(20 + k, k % NW, 64'(k + 1), 8'hFF);
      @(negedge clk);
      st_valid = 1'b1;
      st_addr  = AW'(20 + NE) << OFFW;
      st_data  = 64'h4242;
      st_be    = 8'h03;
      for (int k = 0; k < 3; k++) begin
         #1;
         chk(st_ready == 1'b0, "R10", LW'(st_ready), '0);
         @(negedge clk);
      end
      st_valid = 1'b0;
      hold_bus = 1'b0;
      do_store(20 + NE, 0, 64'h4242, 8'h03);
      pulse_flush();
      wait_empty("R10");

      // constrained random mix
      for (int n = 0; n < 400; n++) begin
         int blk, w, gap;
         logic [SB-1:0] be;
         blk = 32 + int'($urandom % 6);
         w   = int'($urandom % NW);
         be  = (($urandom % 4) == 0) ? 8'hFF : SB'($urandom % 255 + 1);
         do_store(blk, w, {$urandom, $urandom}, be);
         gap = int'($urandom % 6);
         if (gap == 5) repeat (TO + 2) @(negedge clk);
         else repeat (gap) @(negedge clk);
         if (($urandom % 20) == 0) pulse_flush();
      end
      pulse_flush();
      wait_empty("R11");
      chk(req_cnt == wr_cnt, "R11", LW'(wr_cnt), LW'(req_cnt));

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule